// File: doc/BRIEF.md
# Dual-Mode Serial Configuration Port

This block is the slave side of a configuration port. Through it an external controller reads and writes a bank of 8-bit control registers. Three shared pins carry the traffic: an enable/select pin, a serial clock and a serial data line. The data line is open-drain. The port speaks two protocols on these pins. One is a two-wire, I2C-style bus with START/STOP framing and acknowledges. The other is a three-wire, SPI-style write-only stream framed by an active-low select.

After reset the port listens as a two-wire slave. In that mode the select pin gives the lowest bit of the device address. The first high-to-low edge on the select pin moves the port into three-wire mode, and it stays there until the next reset. Every register is presented as a parallel output, so the rest of the chip reads its configuration directly. Writing a one into bit 7 of register 0 returns the whole bank to its reset contents.

All pins pass through two-flop synchronizers into the system clock. That clock must run at least eight times faster than the serial clock. Every edge, START and STOP is detected in the system clock domain.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset the registers hold their defaults: index 0 = 0x06, 1 = 0x1C, 2 = 0xC3, 3 = 0xFC, 8 = 0x80, and every other index = 0x00. The data line is not driven (`cdata_oe` = 0), and the port is in two-wire mode.
- R2: In two-wire mode the port answers the 7-bit address {0b001000, select pin level}. It acknowledges each received byte by pulling the data line low during the ninth clock. It only ever starts driving while the serial clock is low.
- R3: A two-wire write is: address byte with R/W=0, then the register index byte, then the data byte. Each byte is sent MSB first and sampled while the clock is high. The data byte is stored at that index.
- R4: A two-wire transfer whose address byte does not match gets no acknowledge on any byte and changes no register.
- R5: A two-wire read has two steps. First a write-direction transfer sets the index. Then an address byte with R/W=1 returns that register MSB first. The two steps may be joined by a repeated START, or by a STOP followed by a new START.
- R6: A write to an index at or above the bank size (16 by default) is acknowledged but changes no register. A read from such an index returns 0x00.
- R7: Writing a value with bit 7 set to index 0 returns every register to its R1 default.
- R8: A falling edge on the select pin puts the port in three-wire mode. A three-wire write is 24 bits sampled on rising serial clock edges, MSB first: header byte 0x20, then index, then data. The data is stored at the index.
- R9: A three-wire frame whose header is not exactly 0x20 (wrong address, or R/W=1) changes no register.
- R10: Three-wire mode lasts until reset. In that mode the data line is never driven, and two-wire traffic gets no acknowledge and writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_pin | input | 1 | Three-wire select (active low) / two-wire address bit 0 |
| cclk_pin | input | 1 | Serial clock for both protocols |
| cdata_in | input | 1 | Level sensed on the serial data line |
| cdata_oe | output | 1 | When 1, the pad pulls the data line low |
| reg_out | output | NREGS*8 | All registers, index i in bits [8i+7:8i] |

## Verification
The hardest state to reach is the hand-over between the two steps of a read. The index must survive a repeated START, and the port must then switch from receiving to driving data on the falling clock edge that ends the address acknowledge. The bench's two-wire master models the open-drain line as the AND of its own drive and the port's pull-down. It runs the read both with a repeated START and with a STOP-then-START, and samples each data bit while the clock is high. It also enters three-wire mode only after all two-wire checks, because the mode cannot be left without a reset. It then replays a two-wire transfer to show that the bus is ignored.

// File: rtl/cfgp_pkg.sv
`timescale 1ns/1ps
package cfgp_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    TW_IDLE, TW_RX, TW_ACK, TW_TX, TW_WAIT
  } tw_state_e;

  typedef enum logic [1:0] {
    PH_ADDR, PH_INDEX, PH_DATA
  } tw_phase_e;

  function automatic byte_t reg_default(input int idx);
    case (idx)
      0:       return 8'h06;
      1:       return 8'h1C;
      2:       return 8'hC3;
      3:       return 8'hFC;
      8:       return 8'h80;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfgp_sync.sv
`timescale 1ns/1ps
module cfgp_sync #(
  parameter int               WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/cfgp_spi_rx.sv
`timescale 1ns/1ps
module cfgp_spi_rx import cfgp_pkg::*; #(
  parameter byte_t HEADER = 8'h20
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  cs_n,
  input  logic  sclk_rise,
  input  logic  sdi,
  output logic  wr_en,
  output byte_t wr_addr,
  output byte_t wr_data
);
  localparam int FRAME  = 3 * BYTE_W;
  localparam int CNT_W  = $clog2(FRAME + 1);
  localparam int HOLD_W = FRAME - 1;

  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [HOLD_W-1:0] sh_q, sh_n;

  always_comb begin
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    wr_en   = 1'b0;
    wr_addr = sh_q[2*BYTE_W-2 -: BYTE_W];
    wr_data = {sh_q[BYTE_W-2:0], sdi};
    if (!en || cs_n) begin
      cnt_n = '0;
    end else if (sclk_rise && (cnt_q != CNT_W'(FRAME))) begin
      sh_n  = {sh_q[HOLD_W-2:0], sdi};
      cnt_n = cnt_q + CNT_W'(1);
      if ((cnt_q == CNT_W'(FRAME - 1)) && (sh_q[HOLD_W-1 -: BYTE_W] == HEADER)) begin
        wr_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
    end
  end
endmodule

// File: rtl/cfgp_twi_slave.sv
`timescale 1ns/1ps
module cfgp_twi_slave import cfgp_pkg::*; #(
  parameter logic [5:0] DEV_ID = 6'b001000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  sda_s,
  input  logic  scl_rise,
  input  logic  scl_fall,
  input  logic  bus_start,
  input  logic  bus_stop,
  input  logic  ad0,
  input  byte_t rd_data,
  output byte_t ptr,
  output logic  wr_en,
  output byte_t wr_data,
  output logic  sda_oe
);
  tw_state_e  state_q, state_n;
  tw_phase_e  phase_q, phase_n;
  logic [3:0] cnt_q, cnt_n;
  byte_t      sh_q, sh_n;
  byte_t      ptr_q, ptr_n;
  logic       rw_q, rw_n;
  logic       oe_q, oe_n;

  always_comb begin
    state_n = state_q;
    phase_n = phase_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    ptr_n   = ptr_q;
    rw_n    = rw_q;
    oe_n    = oe_q;
    wr_en   = 1'b0;
    if (!en) begin
      state_n = TW_IDLE;
      oe_n    = 1'b0;
    end else if (bus_start) begin
      state_n = TW_RX;
      phase_n = PH_ADDR;
      cnt_n   = '0;
      oe_n    = 1'b0;
    end else if (bus_stop) begin
      state_n = TW_IDLE;
      oe_n    = 1'b0;
    end else begin
      case (state_q)
        TW_RX: begin
          if (scl_rise) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall && (cnt_q == 4'd8)) begin
            case (phase_q)
              PH_ADDR: begin
                if (sh_q[7:1] == {DEV_ID, ad0}) begin
                  rw_n    = sh_q[0];
                  oe_n    = 1'b1;
                  state_n = TW_ACK;
                end else begin
                  state_n = TW_WAIT;
                end
              end
              PH_INDEX: begin
                ptr_n   = sh_q;
                oe_n    = 1'b1;
                state_n = TW_ACK;
              end
              default: begin
                wr_en   = 1'b1;
                oe_n    = 1'b1;
                state_n = TW_ACK;
              end
            endcase
          end
        end
        TW_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if ((phase_q == PH_ADDR) && rw_q) begin
              sh_n    = rd_data;
              oe_n    = ~rd_data[BYTE_W-1];
              state_n = TW_TX;
            end else begin
              oe_n    = 1'b0;
              state_n = TW_RX;
              phase_n = (phase_q == PH_ADDR) ? PH_INDEX : PH_DATA;
            end
          end
        end
        TW_TX: begin
          if (scl_rise) begin
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              oe_n    = 1'b0;
              state_n = TW_WAIT;
            end else begin
              sh_n = {sh_q[BYTE_W-2:0], 1'b0};
              oe_n = ~sh_q[BYTE_W-2];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TW_IDLE;
      phase_q <= PH_ADDR;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      ptr_q   <= ptr_n;
      rw_q    <= rw_n;
      oe_q    <= oe_n;
    end
  end

  assign ptr     = ptr_q;
  assign wr_data = sh_q;
  assign sda_oe  = oe_q;
endmodule

// File: rtl/cfgp_regbank.sv
`timescale 1ns/1ps
module cfgp_regbank import cfgp_pkg::*; #(
  parameter int NREGS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  byte_t                   wr_addr,
  input  byte_t                   wr_data,
  input  byte_t                   rd_addr,
  output byte_t                   rd_data,
  output logic [NREGS*BYTE_W-1:0] regs_flat
);
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

  byte_t regs_q [NREGS];
  logic  soft_rst;

  assign soft_rst = wr_en && (wr_addr == 8'h00) && wr_data[BYTE_W-1];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= reg_default(g);
      end else if (soft_rst) begin
        regs_q[g] <= reg_default(g);
      end else if (wr_en && (wr_addr == BYTE_W'(g))) begin
        regs_q[g] <= wr_data;
      end
    end
    assign regs_flat[g*BYTE_W +: BYTE_W] = regs_q[g];
  end

  always_comb begin
    if (rd_addr < BYTE_W'(NREGS)) rd_data = regs_q[rd_addr[IDX_W-1:0]];
    else                          rd_data = '0;
  end
endmodule

// File: rtl/cfg_serial_port.sv
`timescale 1ns/1ps
module cfg_serial_port import cfgp_pkg::*; #(
  parameter int         NREGS  = 16,
  parameter logic [5:0] DEV_ID = 6'b001000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_pin,
  input  logic                    cclk_pin,
  input  logic                    cdata_in,
  output logic                    cdata_oe,
  output logic [NREGS*BYTE_W-1:0] reg_out
);
  localparam byte_t SPI_HDR = {DEV_ID, 2'b00};

  logic [1:0] bus_s, bus_d;
  logic       ce_s, ce_d;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, bus_start, bus_stop, ce_fall;
  logic       spi_mode_q, spi_mode_n;

  cfgp_sync #(.WIDTH(2), .RST_VAL(2'b11)) u_sync_bus (
    .clk(clk), .rst_n(rst_n), .d({cclk_pin, cdata_in}), .q(bus_s)
  );
  cfgp_sync #(.WIDTH(1), .RST_VAL(1'b0)) u_sync_ce (
    .clk(clk), .rst_n(rst_n), .d(ce_pin), .q(ce_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_d      <= 2'b11;
      ce_d       <= 1'b0;
      spi_mode_q <= 1'b0;
    end else begin
      bus_d      <= bus_s;
      ce_d       <= ce_s;
      spi_mode_q <= spi_mode_n;
    end
  end

  assign scl_s     = bus_s[1];
  assign sda_s     = bus_s[0];
  assign scl_rise  = scl_s & ~bus_d[1];
  assign scl_fall  = ~scl_s & bus_d[1];
  assign bus_start = scl_s & bus_d[1] & bus_d[0] & ~sda_s;
  assign bus_stop  = scl_s & bus_d[1] & ~bus_d[0] & sda_s;
  assign ce_fall   = ce_d & ~ce_s;

  always_comb begin
    spi_mode_n = spi_mode_q;
    if (ce_fall) spi_mode_n = 1'b1;
  end

  logic  spi_we, twi_we, wr_en;
  byte_t spi_addr, spi_data, twi_ptr, twi_data, wr_addr, wr_data, rd_data;

  cfgp_spi_rx #(.HEADER(SPI_HDR)) u_spi (
    .clk(clk), .rst_n(rst_n), .en(spi_mode_q), .cs_n(ce_s),
    .sclk_rise(scl_rise), .sdi(sda_s),
    .wr_en(spi_we), .wr_addr(spi_addr), .wr_data(spi_data)
  );

  cfgp_twi_slave #(.DEV_ID(DEV_ID)) u_twi (
    .clk(clk), .rst_n(rst_n), .en(~spi_mode_q), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .ad0(ce_s),
    .rd_data(rd_data), .ptr(twi_ptr), .wr_en(twi_we),
    .wr_data(twi_data), .sda_oe(cdata_oe)
  );

  always_comb begin
    if (spi_mode_q) begin
      wr_en   = spi_we;
      wr_addr = spi_addr;
      wr_data = spi_data;
    end else begin
      wr_en   = twi_we;
      wr_addr = twi_ptr;
      wr_data = twi_data;
    end
  end

  cfgp_regbank #(.NREGS(NREGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(twi_ptr), .rd_data(rd_data),
    .regs_flat(reg_out)
  );
endmodule

// File: rtl/cfg_serial_port_chk.sv
`timescale 1ns/1ps
module cfg_serial_port_chk #(
  parameter int NREGS = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               spi_mode,
  input logic               scl_s,
  input logic               cdata_oe,
  input logic               wr_en,
  input logic [7:0]         wr_addr,
  input logic [7:0]         wr_data,
  input logic [NREGS*8-1:0] regs
);
  logic first_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) first_q <= 1'b1;
    else        first_q <= 1'b0;
  end

  assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (!rst_n)
    first_q |-> (regs[7:0] == 8'h06 && regs[71:64] == 8'h80 && !cdata_oe && !spi_mode));

  assert_drive_on_low_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cdata_oe) |-> !scl_s);

  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 8'h01) |=> (regs[15:8] == $past(wr_data)));

  assert_soft_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 8'h00 && wr_data[7]) |=> (regs[7:0] == 8'h06 && regs[23:16] == 8'hC3));

  assert_mode_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode |=> spi_mode);

  assert_no_drive_in_spi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode |-> !cdata_oe);
endmodule

bind cfg_serial_port cfg_serial_port_chk #(.NREGS(NREGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode_q), .scl_s(scl_s),
  .cdata_oe(cdata_oe), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .regs(reg_out)
);

// File: tb/tb_cfg_serial_port.sv
`timescale 1ns/1ps
module tb_cfg_serial_port;
  localparam int NREGS = 16;
  localparam int Q     = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_m = 1'b1, scl_m = 1'b1, sda_m = 1'b1;
  logic cdata_oe;
  logic [NREGS*8-1:0] reg_out;
  wire  sda_line = sda_m & ~cdata_oe;

  always #2.5 clk = ~clk;

  cfg_serial_port #(.NREGS(NREGS)) dut (
    .clk(clk), .rst_n(rst_n), .ce_pin(ce_m), .cclk_pin(scl_m),
    .cdata_in(sda_line), .cdata_oe(cdata_oe), .reg_out(reg_out)
  );

  typedef struct {
    string      tag;
    bit         is_reg;
    int         idx;
    logic [7:0] exp;
    logic [7:0] act;
  } item_t;

  item_t q[$];
  int    n_tests = 0;
  int    n_fails = 0;
  bit    done    = 1'b0;
  event  sample_ev;

  task automatic exp_reg(input string tag, input int idx, input logic [7:0] v);
    item_t it;
    it.tag = tag; it.is_reg = 1'b1; it.idx = idx; it.exp = v; it.act = 8'h00;
    q.push_back(it);
  endtask

  task automatic exp_bus(input string tag, input logic [7:0] act, input logic [7:0] v);
    item_t it;
    it.tag = tag; it.is_reg = 1'b0; it.idx = 0; it.exp = v; it.act = act;
    q.push_back(it);
  endtask

  task automatic flush();
    -> sample_ev;
    #20;
  endtask

  initial begin : monitor
    forever begin
      @(sample_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] a;
        it = q.pop_front();
        a = it.is_reg ? reg_out[it.idx*8 +: 8] : it.act;
        n_tests++;
        if (a !== it.exp) begin
          n_fails++;
          $display("FAIL %s: idx %0d actual %02h expected %02h", it.tag, it.idx, a, it.exp);
        end
      end
    end
  end

  task automatic tw_start();
    sda_m = 1'b1; #(Q); scl_m = 1'b1; #(Q); sda_m = 1'b0; #(Q); scl_m = 1'b0; #(Q);
  endtask
  task automatic tw_stop();
    sda_m = 1'b0; #(Q); scl_m = 1'b1; #(Q); sda_m = 1'b1; #(Q);
  endtask
  task automatic tw_bit_out(input logic b);
    sda_m = b; #(Q); scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #(Q);
  endtask
  task automatic tw_bit_in(output logic b);
    sda_m = 1'b1; #(Q); scl_m = 1'b1; #(Q); b = sda_line; #(Q); scl_m = 1'b0; #(Q);
  endtask
  task automatic tw_wr_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) tw_bit_out(v[i]);
    tw_bit_in(ack);
  endtask
  task automatic tw_rd_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) tw_bit_in(v[i]);
    tw_bit_out(1'b1);
  endtask

  task automatic tw_write(input logic [7:0] dev, input logic [7:0] idx,
                          input logic [7:0] v, input logic acked, input string tag);
    logic a0, a1, a2;
    tw_start();
    tw_wr_byte(dev, a0);
    tw_wr_byte(idx, a1);
    tw_wr_byte(v, a2);
    tw_stop();
    exp_bus(tag, {7'b0, a0}, {7'b0, ~acked});
    exp_bus(tag, {7'b0, a1}, {7'b0, ~acked});
    exp_bus(tag, {7'b0, a2}, {7'b0, ~acked});
  endtask

  task automatic tw_read(input logic [7:0] idx, input logic use_rs,
                         input logic [7:0] v, input string tag);
    logic a0, a1, a2;
    logic [7:0] d;
    tw_start();
    tw_wr_byte(8'h22, a0);
    tw_wr_byte(idx, a1);
    if (!use_rs) tw_stop();
    tw_start();
    tw_wr_byte(8'h23, a2);
    tw_rd_byte(d);
    tw_stop();
    exp_bus(tag, {7'b0, a0 | a1 | a2}, 8'h00);
    exp_bus(tag, d, v);
  endtask

  task automatic spi_write(input logic [7:0] h, input logic [7:0] idx, input logic [7:0] v);
    logic [23:0] fr;
    fr = {h, idx, v};
    ce_m = 1'b0; #(Q); scl_m = 1'b0; #(Q);
    for (int i = 23; i >= 0; i--) begin
      sda_m = fr[i]; #(Q); scl_m = 1'b1; #(Q); scl_m = 1'b0;
    end
    #(Q); ce_m = 1'b1; sda_m = 1'b1; #(2*Q);
  endtask

  initial begin : watchdog
    #(5 * 150000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fails);
      $finish;
    end
  end

  initial begin : driver
    #(53); rst_n = 1'b1; #(100);

    // R1: reset defaults and released line
    exp_reg("R1", 0, 8'h06); exp_reg("R1", 1, 8'h1C); exp_reg("R1", 2, 8'hC3);
    exp_reg("R1", 3, 8'hFC); exp_reg("R1", 8, 8'h80); exp_reg("R1", 5, 8'h00);
    exp_bus("R1", {7'b0, cdata_oe}, 8'h00);
    flush();

    // R2/R3: matching address (AD0 = 1) is acknowledged and data stored
    tw_write(8'h22, 8'h09, 8'h5A, 1'b1, "R2_R3");
    exp_reg("R3", 9, 8'h5A);
    tw_write(8'h22, 8'h01, 8'h3C, 1'b1, "R3");
    exp_reg("R3", 1, 8'h3C);
    flush();

    // R4: address with wrong AD0 bit ignored
    tw_write(8'h20, 8'h09, 8'h11, 1'b0, "R4");
    exp_reg("R4", 9, 8'h5A);
    flush();

    // R5: read with repeated START and with STOP/START
    tw_read(8'h09, 1'b1, 8'h5A, "R5");
    tw_read(8'h02, 1'b0, 8'hC3, "R5");
    flush();

    // R6: out-of-range index
    tw_write(8'h22, 8'h40, 8'h77, 1'b1, "R6");
    exp_reg("R6", 0, 8'h06);
    exp_reg("R6", 9, 8'h5A);
    tw_read(8'h40, 1'b1, 8'h00, "R6");
    flush();

    // R7: soft reset through bit 7 of index 0
    tw_write(8'h22, 8'h00, 8'h80, 1'b1, "R7");
    exp_reg("R7", 0, 8'h06); exp_reg("R7", 1, 8'h1C); exp_reg("R7", 9, 8'h00);
    flush();

    // R8: select falling edge enters three-wire mode, write lands
    spi_write(8'h20, 8'h09, 8'hA5);
    exp_reg("R8", 9, 8'hA5);
    spi_write(8'h20, 8'h0B, 8'hC4);
    exp_reg("R8", 11, 8'hC4);
    flush();

    // R9: wrong header or read direction dropped
    spi_write(8'h22, 8'h09, 8'h33);
    spi_write(8'h21, 8'h09, 8'h33);
    exp_reg("R9", 9, 8'hA5);
    flush();

    // R10: two-wire traffic ignored in three-wire mode
    tw_write(8'h22, 8'h09, 8'h66, 1'b0, "R10");
    exp_reg("R10", 9, 8'hA5);
    exp_bus("R10", {7'b0, cdata_oe}, 8'h00);
    flush();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fails);
    $finish;
  end
endmodule